// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the configuration and delivery state for a bank of interrupt sources. It turns source events into deliveries toward an interrupt presenter. Each delivery carries a target server, a priority and a global source number. The presenter can send back three messages: reject, end-of-interrupt (EOI) and a bulk resend request. The controller updates the state of the source concerned for each one.

Every source is fixed at build time as either level-sensitive or message-style. A level source delivers while its line is high and it has not already been delivered. A message source delivers once for each event. Its event is held back as pending when the source is masked. A priority of 0xFF masks a source. Each source also keeps a saved priority alongside the live one, for use when a masked source is later restored.

All operations enter through a single command port and act on one source per cycle. A resend request starts a scan. The scan walks the sources in ascending index order, one per cycle, and the command port is not ready while it runs. The controller has two states. ST_IDLE accepts commands. A resend command moves it to ST_SCAN (transition "scan start"). It returns to ST_IDLE after the last source has been visited (transition "scan done").

Top module: `isc_source_ctrl`

## Requirements
- R1: After reset all sources are masked (priority 0xFF), all status is clear, cmd_ready is 1 and dlv_valid is 0. A message event on any source right after reset produces no delivery.
- R2: Source index i has global number 0x1000 + i. A number outside [0x1000, 0x1000 + NSRC) makes a line, configure, reject or EOI command have no effect. An op code other than the five listed in R3 to R10 also has no effect.
- R3: Op 0 (line) with cmd_line = 1 on a message source is an event. If the source is unmasked, the event delivers at once with the stored server and priority. If it is masked, the event sets masked-pending (status bit 3) and does not deliver.
- R4: Op 1 (configure) stores the server, priority and saved priority. On a message source, it delivers only when masked-pending is set and the new priority is not 0xFF, and it then clears masked-pending. A second configure does not deliver again.
- R5: Op 0 on a level source copies cmd_line into the asserted bit (status bit 0). The source delivers and sets sent (bit 1) when its priority is not 0xFF, it is asserted and it is not yet sent. A falling line never delivers.
- R6: A configure command on a level source runs the level delivery check of R5 with the new priority.
- R7: Op 2 (reject) sets rejected (bit 2) and clears sent. A rejected level source that is still asserted delivers again on the next resend scan.
- R8: Op 3 (EOI) on a level source clears sent and runs the level check again. EOI on a message source has no effect.
- R9: During a scan, a message source is delivered again only if rejected is set. The scan clears rejected and delivers only if the source is unmasked, so a second scan does not deliver it again.
- R10: Op 4 (resend) starts a scan that visits source i in the (i+1)-th cycle after acceptance. Deliveries come out in ascending index order. cmd_ready is 0 for exactly NSRC cycles and then returns to 1.
- R11: Every delivery appears on dlv_* in the cycle after the command or scan step that causes it. A delivery never carries priority 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted this cycle (low during a scan) |
| cmd_op | input | 3 | 0 line, 1 configure, 2 reject, 3 EOI, 4 resend |
| cmd_num | input | NUM_W | Global source number |
| cmd_line | input | 1 | Line value for op 0 |
| cmd_server | input | 4 | Target server for op 1 |
| cmd_prio | input | 8 | Priority for op 1 |
| cmd_saved | input | 8 | Saved priority for op 1 |
| dlv_valid | output | 1 | Delivery strobe |
| dlv_server | output | 4 | Delivery target server |
| dlv_num | output | NUM_W | Delivered global source number |
| dlv_prio | output | 8 | Delivered priority |

## Verification
The assertions check four things on every cycle: no delivery carries a masked priority, delivered numbers stay in the valid range, a reject always leaves rejected set and sent cleared, and the scan index advances by exactly one per scan cycle. Other behaviour can only be shown by the bench's scenarios. This covers a held-back message event being released by a later configure, a level source redelivering after EOI or after a reject-and-resend, a second scan staying silent, and the order of scan deliveries. The bench shows these by comparing every delivery against a reference model of the source table. It drives both directed sequences and seeded random commands.

// File: rtl/isc_pkg.sv
package isc_pkg;

    parameter int ISC_SRV_W = 4;
    localparam logic [7:0] PRIO_OFF = 8'hFF;

    // status bit positions
    localparam int ST_ASSERTED = 0;
    localparam int ST_SENT     = 1;
    localparam int ST_REJECTED = 2;
    localparam int ST_MPEND    = 3;

    typedef enum logic [2:0] {
        OP_LINE   = 3'd0,
        OP_CONFIG = 3'd1,
        OP_REJECT = 3'd2,
        OP_EOI    = 3'd3,
        OP_RESEND = 3'd4
    } isc_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } isc_state_e;

    typedef struct packed {
        logic [ISC_SRV_W-1:0] server;
        logic [7:0]           prio;
        logic [7:0]           saved;
        logic [3:0]           status;
    } isc_entry_t;

endpackage

// File: rtl/isc_rule.sv
module isc_rule
    import isc_pkg::*;
(
    input  isc_op_e              op,
    input  logic                 is_level,
    input  logic                 line,
    input  logic [ISC_SRV_W-1:0] cfg_srv,
    input  logic [7:0]           cfg_prio,
    input  logic [7:0]           cfg_saved,
    input  isc_entry_t           ent_i,
    output isc_entry_t           ent_o,
    output logic                 fire
);
    logic lvl_check;

    always_comb begin
        ent_o     = ent_i;
        fire      = 1'b0;
        lvl_check = 1'b0;
        unique case (op)
            OP_LINE: begin
                if (is_level) begin
                    ent_o.status[ST_ASSERTED] = line;
                    lvl_check = 1'b1;
                end else if (line) begin
                    if (ent_i.prio == PRIO_OFF) ent_o.status[ST_MPEND] = 1'b1;
                    else                        fire = 1'b1;
                end
            end
            OP_CONFIG: begin
                ent_o.server = cfg_srv;
                ent_o.prio   = cfg_prio;
                ent_o.saved  = cfg_saved;
                if (is_level) begin
                    lvl_check = 1'b1;
                end else if (ent_i.status[ST_MPEND] && cfg_prio != PRIO_OFF) begin
                    ent_o.status[ST_MPEND] = 1'b0;
                    fire = 1'b1;
                end
            end
            OP_REJECT: begin
                ent_o.status[ST_REJECTED] = 1'b1;
                ent_o.status[ST_SENT]     = 1'b0;
            end
            OP_EOI: begin
                if (is_level) begin
                    ent_o.status[ST_SENT] = 1'b0;
                    lvl_check = 1'b1;
                end
            end
            OP_RESEND: begin
                if (is_level) begin
                    lvl_check = 1'b1;
                end else if (ent_i.status[ST_REJECTED]) begin
                    ent_o.status[ST_REJECTED] = 1'b0;
                    fire = (ent_i.prio != PRIO_OFF);
                end
            end
            default: ;
        endcase
        if (lvl_check && ent_o.prio != PRIO_OFF &&
            ent_o.status[ST_ASSERTED] && !ent_o.status[ST_SENT]) begin
            ent_o.status[ST_SENT] = 1'b1;
            fire = 1'b1;
        end
    end
endmodule

// File: rtl/isc_seq.sv
module isc_seq
    import isc_pkg::*;
#(
    parameter int NSRC  = 8,
    localparam int IDX_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             in_scan,
    output logic [IDX_W-1:0] scan_idx
);
    isc_state_e state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_SCAN;
                idx_d   = '0;
            end
            ST_SCAN: begin
                if (idx_q == IDX_W'(NSRC - 1)) state_d = ST_IDLE;
                else                           idx_d   = idx_q + 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign in_scan  = (state_q == ST_SCAN);
    assign scan_idx = idx_q;

    // R10
    scan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN && $past(state_q) == ST_SCAN) |-> idx_q == $past(idx_q) + 1'b1);
endmodule

// File: rtl/isc_source_ctrl.sv
module isc_source_ctrl
    import isc_pkg::*;
#(
    parameter int               NSRC      = 8,
    parameter int               NUM_W     = 16,
    parameter int               BUID      = 1,
    parameter logic [NSRC-1:0]  LEVEL_MAP = 8'hF0,
    localparam int              IDX_W     = $clog2(NSRC),
    localparam int              BASE      = BUID << 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [2:0]           cmd_op,
    input  logic [NUM_W-1:0]     cmd_num,
    input  logic                 cmd_line,
    input  logic [ISC_SRV_W-1:0] cmd_server,
    input  logic [7:0]           cmd_prio,
    input  logic [7:0]           cmd_saved,
    output logic                 dlv_valid,
    output logic [ISC_SRV_W-1:0] dlv_server,
    output logic [NUM_W-1:0]     dlv_num,
    output logic [7:0]           dlv_prio
);
    isc_entry_t tbl_q [NSRC];

    logic [NUM_W-1:0] off;
    logic             num_ok, accept, start, in_scan, act_en, fire;
    logic [IDX_W-1:0] scan_idx, act_idx;
    isc_op_e          act_op;
    isc_entry_t       ent_new;

    assign off       = cmd_num - NUM_W'(BASE);
    assign num_ok    = (cmd_num >= NUM_W'(BASE)) && (off < NUM_W'(NSRC));
    assign cmd_ready = !in_scan;
    assign accept    = cmd_valid && cmd_ready;
    assign start     = accept && cmd_op == OP_RESEND;

    isc_seq #(.NSRC(NSRC)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .in_scan(in_scan), .scan_idx(scan_idx)
    );

    assign act_idx = in_scan ? scan_idx : off[IDX_W-1:0];
    assign act_op  = in_scan ? OP_RESEND : isc_op_e'(cmd_op);
    assign act_en  = in_scan || (accept && num_ok && cmd_op <= 3'd3);

    isc_rule u_rule (
        .op(act_op), .is_level(LEVEL_MAP[act_idx]), .line(cmd_line),
        .cfg_srv(cmd_server), .cfg_prio(cmd_prio), .cfg_saved(cmd_saved),
        .ent_i(tbl_q[act_idx]), .ent_o(ent_new), .fire(fire)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) begin
                tbl_q[i].server <= '0;
                tbl_q[i].prio   <= PRIO_OFF;
                tbl_q[i].saved  <= PRIO_OFF;
                tbl_q[i].status <= '0;
            end
            dlv_valid  <= 1'b0;
            dlv_server <= '0;
            dlv_num    <= '0;
            dlv_prio   <= '0;
        end else begin
            if (act_en) tbl_q[act_idx] <= ent_new;
            dlv_valid <= act_en && fire;
            if (act_en && fire) begin
                dlv_server <= ent_new.server;
                dlv_prio   <= ent_new.prio;
                dlv_num    <= NUM_W'(BASE) + NUM_W'(act_idx);
            end
        end
    end

    // R11
    deliv_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> dlv_prio != PRIO_OFF);
    // R2
    deliv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dlv_valid |-> (dlv_num >= NUM_W'(BASE) && dlv_num < NUM_W'(BASE + NSRC)));
    // R7
    reject_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && !in_scan && act_op == OP_REJECT) |=>
        (tbl_q[$past(act_idx)].status[ST_REJECTED] && !tbl_q[$past(act_idx)].status[ST_SENT]));
endmodule

// File: tb/isc_source_ctrl_bench.sv
`timescale 1ns/1ps
module isc_source_ctrl_bench;
    localparam int NSRC = 8;
    localparam logic [7:0] LVL = 8'hF0;

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, cmd_line = 0;
    logic [2:0] cmd_op = 0;
    logic [15:0] cmd_num = 0;
    logic [3:0] cmd_server = 0;
    logic [7:0] cmd_prio = 0, cmd_saved = 0;
    logic cmd_ready, dlv_valid;
    logic [3:0] dlv_server;
    logic [15:0] dlv_num;
    logic [7:0] dlv_prio;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [3:0] m_srv [NSRC];
    logic [7:0] m_prio [NSRC];
    logic [3:0] m_st [NSRC];
    bit ex_v;
    logic [3:0] ex_srv;
    logic [7:0] ex_prio;
    logic [15:0] ex_num;

    always #5 clk = ~clk;

    isc_source_ctrl u_isc_source_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_num(cmd_num), .cmd_line(cmd_line),
        .cmd_server(cmd_server), .cmd_prio(cmd_prio), .cmd_saved(cmd_saved),
        .dlv_valid(dlv_valid), .dlv_server(dlv_server), .dlv_num(dlv_num),
        .dlv_prio(dlv_prio)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_dlv(input string tag);
        check(dlv_valid == ex_v, tag, "dlv_valid", {31'd0, dlv_valid}, {31'd0, ex_v});
        if (ex_v && dlv_valid) begin
            check(dlv_num == ex_num, tag, "dlv_num", {16'd0, dlv_num}, {16'd0, ex_num});
            check(dlv_server == ex_srv, tag, "dlv_server", {28'd0, dlv_server}, {28'd0, ex_srv});
            check(dlv_prio == ex_prio, tag, "dlv_prio", {24'd0, dlv_prio}, {24'd0, ex_prio});
        end
    endtask

    // reference model of one source step
    task automatic model(input int op, input int i, input bit line,
                         input logic [3:0] srv, input logic [7:0] prio);
        bit lvl = LVL[i];
        bit chk = 0;
        ex_v = 0;
        case (op)
            0: if (lvl) begin m_st[i][0] = line; chk = 1; end
               else if (line) begin
                   if (m_prio[i] == 8'hFF) m_st[i][3] = 1; else ex_v = 1;
               end
            1: begin
                m_srv[i] = srv; m_prio[i] = prio;
                if (lvl) chk = 1;
                else if (m_st[i][3] && prio != 8'hFF) begin m_st[i][3] = 0; ex_v = 1; end
            end
            2: begin m_st[i][2] = 1; m_st[i][1] = 0; end
            3: if (lvl) begin m_st[i][1] = 0; chk = 1; end
            4: if (lvl) chk = 1;
               else if (m_st[i][2]) begin m_st[i][2] = 0; ex_v = (m_prio[i] != 8'hFF); end
            default: ;
        endcase
        if (chk && m_prio[i] != 8'hFF && m_st[i][0] && !m_st[i][1]) begin
            m_st[i][1] = 1; ex_v = 1;
        end
        ex_srv = m_srv[i]; ex_prio = m_prio[i]; ex_num = 16'h1000 + 16'(i);
    endtask

    task automatic issue(input int op, input logic [15:0] num, input bit line,
                         input logic [3:0] srv, input logic [7:0] prio, input string tag);
        cmd_valid = 1; cmd_op = 3'(op); cmd_num = num; cmd_line = line;
        cmd_server = srv; cmd_prio = prio; cmd_saved = prio ^ 8'h0F;
        ex_v = 0;
        if (op <= 3 && num >= 16'h1000 && num < 16'h1000 + NSRC)
            model(op, int'(num - 16'h1000), line, srv, prio);
        @(posedge clk); #1;
        cmp_dlv(tag);
        cmd_valid = 0;
        if (op == 4) begin
            // R10
            check(cmd_ready == 0, "R10", "ready_in_scan", {31'd0, cmd_ready}, 0);
            for (int i = 0; i < NSRC; i++) begin
                model(4, i, 0, 0, 0);
                @(posedge clk); #1;
                cmp_dlv(tag);
                check(cmd_ready == (i == NSRC - 1), "R10", "ready_step",
                      {31'd0, cmd_ready}, (i == NSRC - 1) ? 1 : 0);
            end
        end
    endtask

    function automatic logic [15:0] gn(input int i);
        return 16'h1000 + 16'(i);
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NSRC; i++) begin m_srv[i] = 0; m_prio[i] = 8'hFF; m_st[i] = 0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        check(cmd_ready == 1, "R1", "ready", {31'd0, cmd_ready}, 1);
        check(dlv_valid == 0, "R1", "dlv_valid", {31'd0, dlv_valid}, 0);
        issue(0, gn(0), 1, 0, 0, "R1");            // masked after reset: pending
        issue(1, gn(0), 0, 4'd3, 8'd5, "R4");      // released on unmask
        issue(1, gn(0), 0, 4'd3, 8'd5, "R4");      // no second delivery
        issue(0, gn(0), 1, 0, 0, "R3");            // unmasked event delivers
        issue(0, gn(1), 1, 0, 0, "R3");            // masked event held
        issue(0, 16'h0FFF, 1, 0, 0, "R2");         // below range ignored
        issue(1, gn(NSRC), 0, 4'd1, 8'd2, "R2");   // above range ignored
        issue(6, gn(1), 0, 4'd1, 8'd2, "R2");      // unknown op ignored
        issue(1, gn(1), 0, 4'd9, 8'd7, "R4");      // pending still there: delivers
        issue(3, gn(0), 0, 0, 0, "R8");            // EOI on message: nothing
        issue(0, gn(4), 1, 0, 0, "R5");            // level masked: no delivery
        issue(1, gn(4), 0, 4'd2, 8'd2, "R6");      // configure runs check: delivers
        issue(0, gn(4), 1, 0, 0, "R5");            // already sent
        issue(3, gn(4), 0, 0, 0, "R8");            // EOI redelivers
        issue(0, gn(4), 0, 0, 0, "R5");            // falling line
        issue(3, gn(4), 0, 0, 0, "R8");            // EOI, not asserted: nothing
        issue(0, gn(4), 1, 0, 0, "R5");            // rising again delivers
        issue(2, gn(4), 0, 0, 0, "R7");            // reject level
        issue(2, gn(0), 0, 0, 0, "R7");            // reject message
        issue(1, gn(2), 0, 4'd5, 8'd1, "R9");
        issue(2, gn(2), 0, 0, 0, "R9");
        issue(4, 16'h0, 0, 0, 0, "R9");            // scan: 0, 2, 4 in order
        issue(4, 16'h0, 0, 0, 0, "R9");            // second scan silent
        issue(2, gn(3), 0, 0, 0, "R9");            // masked message rejected
        issue(4, 16'h0, 0, 0, 0, "R10");
        for (int n = 0; n < 400; n++) begin
            int r = $urandom_range(0, 19);
            int k = $urandom_range(0, 9);
            int op = (r < 6) ? 0 : (r < 11) ? 1 : (r < 14) ? 2 : (r < 17) ? 3 : (r < 18) ? 4 : 5;
            logic [15:0] num = (k == 8) ? 16'h0FFF : (k == 9) ? gn(NSRC) : gn(k);
            logic [7:0] pr = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 15));
            issue(op, num, 1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), pr, "R11");
        end
        finish_run();
    end
endmodule